// File: doc/BRIEF.md
# Truncated Fixed-Point Multiplier with Selectable Error Compensation

This block multiplies two unsigned fractions of N fractional bits and returns an N-bit product. It never forms the full 2N-bit result. The partial-product array is treated as three bands. The upper band holds the columns whose weights run from 2^-1 down to 2^-N, and these form the result. The next K columns below them form the guard band, which is summed exactly when a correction is applied. The lowest N-K columns form the dropped band and are never summed.

A two-bit run-time mode decides how the dropped band is compensated. The first choice is plain truncation. The second is a fixed constant, worked out at elaboration from the expected value of the dropped bits. The third is a data-dependent term, in which the bits of the topmost dropped column are counted twice at the guard band's least significant position. The output is registered, so a product appears one clock after its operands are presented.

Top module: `trunc_mul_corr`

## Requirements
- R1: A synchronous, active-high `rst` clears `prod_o` to zero at the clock edge where it is sampled high, whatever the operands are.
- R2: `prod_o` changes only at a rising clock edge. It reflects the operands and mode sampled at that edge, and it holds while the inputs change between edges.
- R3: With `mode_i` = 2'b00 (plain truncation), `prod_o` equals the sum of the partial products a[i]&b[j] with i+j >= N, each weighted 2^(i+j-N), taken modulo 2^N.
- R4: With `mode_i` = 2'b01 (constant correction), all partial products with i+j >= N-K are summed, each weighted 2^(i+j-N+K). The constant CC is added, the sum is shifted right by K, and the low N bits are kept.
- R5: CC is derived from N and K. It equals round-half-up of (E + T) / 2^(N-K). Here E = sum over c < N-K of (c+1)·2^c / 4, which is the expected dropped-band value when every bit is 1 with probability 1/2. T = 2^(N-1) - 2^(N-K-1). For N=4, K=1 this gives CC = 1; for N=6, K=2 it gives CC = 2.
- R6: With `mode_i` = 2'b10 (variable correction), the sum is the same as in R4, but instead of CC it adds twice the number of ones among the partial products with i+j = N-K-1, plus VC = round-half-up of T / 2^(N-K). The sum is then shifted right by K and the low N bits are kept.
- R7: `mode_i` = 2'b11 gives exactly the plain-truncation result of R3.
- R8: The final truncation keeps only N bits, so a corrected sum of 2^N or more wraps. For N=4, K=1, variable mode and a = b = 15, the result is 0.
- R9: In plain-truncation mode, the result never exceeds floor(a·b / 2^N).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Compensation select: 00 truncate, 01 constant, 10 variable, 11 truncate |
| a_i | input | N | Multiplicand, unsigned fraction of N fractional bits |
| b_i | input | N | Multiplier, unsigned fraction of N fractional bits |
| prod_o | output | N | Registered truncated product |

## Verification
Every result is due one rising edge after its operands and mode are applied, because the array sum and the correction are combinational and feed a single output register. The bench changes inputs on the falling edge and samples one time unit after the next rising edge. It also samples right after a falling-edge input change, to show the output still holds the previous product. The expected product comes from integer arithmetic on the requirement formulas, swept over every operand pair and every mode for two sizes.

// File: rtl/tcm_pkg.sv
package tcm_pkg;

  typedef enum logic [1:0] {
    TCM_TRUNC = 2'b00,
    TCM_CONST = 2'b01,
    TCM_VAR   = 2'b10,
    TCM_RSVD  = 2'b11
  } tcm_mode_e;

  // Truncation-error term T in integer units of the 2N-bit product.
  function automatic int trunc_term(int n, int k);
    int base;
    base = n - k;
    return (1 << (n - 1)) - (1 << (base - 1));
  endfunction

  // Constant correction, in units of the guard-band LSB (R5).
  function automatic int cc_units(int n, int k);
    int base;
    int e4;
    base = n - k;
    e4 = 0;
    for (int c = 0; c < base; c++) e4 += (c + 1) << c;
    e4 += 4 * trunc_term(n, k);
    return (e4 + (2 << base)) / (4 << base);
  endfunction

  // Rounded truncation term for variable correction, guard-band LSB units (R6).
  function automatic int vc_units(int n, int k);
    int base;
    base = n - k;
    return (2 * trunc_term(n, k) + (1 << base)) / (2 << base);
  endfunction

endpackage

// File: rtl/tcm_colsum.sv
// Weighted sum of the partial products whose column index lies in [LO, HI],
// expressed in units of column BASE.
module tcm_colsum #(
  parameter int N    = 8,
  parameter int LO   = 0,
  parameter int HI   = 0,
  parameter int BASE = 0,
  parameter int W    = 16
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  output logic [W-1:0] sum_o
);
  localparam int NPP = N * N;

  logic [NPP-1:0] pp;

  for (genvar gi = 0; gi < N; gi++) begin : g_row
    for (genvar gj = 0; gj < N; gj++) begin : g_col
      assign pp[gi*N+gj] = a_i[gi] & b_i[gj];
    end
  end

  always_comb begin
    sum_o = '0;
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) begin
        if ((i + j) >= LO && (i + j) <= HI)
          sum_o = sum_o + (W'(pp[i*N+j]) << (i + j - BASE));
      end
    end
  end
endmodule

// File: rtl/tcm_corr_sel.sv
// Picks the compensation addend that goes on top of the result band.
module tcm_corr_sel
  import tcm_pkg::*;
#(
  parameter int N = 8,
  parameter int K = 3,
  parameter int W = 13
) (
  input  logic [1:0]   mode_i,
  input  logic [W-1:0] guard_sum_i,
  input  logic [W-1:0] edge_cnt_i,
  output logic [W-1:0] addend_o
);
  localparam int CC = cc_units(N, K);
  localparam int VC = vc_units(N, K);

  always_comb begin
    unique case (tcm_mode_e'(mode_i))
      TCM_CONST: addend_o = guard_sum_i + W'(CC);
      TCM_VAR:   addend_o = guard_sum_i + (edge_cnt_i << 1) + W'(VC);
      default:   addend_o = '0;
    endcase
  end
endmodule

// File: rtl/trunc_mul_corr.sv
module trunc_mul_corr
  import tcm_pkg::*;
#(
  parameter int N = 8,
  parameter int K = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   mode_i,
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  output logic [N-1:0] prod_o
);
  localparam int BASE = N - K;
  localparam int W    = N + K + 2;

  logic [W-1:0] res_sum;
  logic [W-1:0] guard_sum;
  logic [W-1:0] edge_cnt;
  logic [W-1:0] addend;
  logic [W-1:0] total;
  logic [N-1:0] prod_q;

  tcm_colsum #(.N(N), .LO(N), .HI(2*N-2), .BASE(BASE), .W(W)) u_res (
    .a_i(a_i), .b_i(b_i), .sum_o(res_sum)
  );

  tcm_colsum #(.N(N), .LO(BASE), .HI(N-1), .BASE(BASE), .W(W)) u_guard (
    .a_i(a_i), .b_i(b_i), .sum_o(guard_sum)
  );

  tcm_colsum #(.N(N), .LO(BASE-1), .HI(BASE-1), .BASE(BASE-1), .W(W)) u_edge (
    .a_i(a_i), .b_i(b_i), .sum_o(edge_cnt)
  );

  tcm_corr_sel #(.N(N), .K(K), .W(W)) u_corr (
    .mode_i(mode_i), .guard_sum_i(guard_sum), .edge_cnt_i(edge_cnt),
    .addend_o(addend)
  );

  assign total = res_sum + addend;

  always_ff @(posedge clk) begin
    if (rst) prod_q <= '0;
    else     prod_q <= total[K +: N];
  end

  assign prod_o = prod_q;

  // Exact product, used only by the checks below.
  logic [2*N-1:0] exact_w;
  assign exact_w = (2*N)'(a_i) * (2*N)'(b_i);

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> prod_o == '0); // R1

  AST_TRUNC_BOUND: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode_i) == TCM_TRUNC) |->
      ({{N{1'b0}}, prod_o} <= ($past(exact_w) >> N))); // R9

  AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(a_i) == '0 &&
     ($past(mode_i) == TCM_VAR || $past(mode_i) == TCM_TRUNC)) |->
      prod_o == '0); // R6

  AST_NO_INNER_WRAP: assert property (@(posedge clk) disable iff (rst)
    total >= res_sum); // R8
endmodule

// File: tb/tb_trunc_mul_corr.sv
module tb_trunc_mul_corr;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] mode;
  logic [3:0] a4, b4, p4;
  logic [5:0] a6, b6, p6;

  int  n_run  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trunc_mul_corr #(.N(4), .K(1)) dut (
    .clk(clk), .rst(rst), .mode_i(mode), .a_i(a4), .b_i(b4), .prod_o(p4)
  );

  trunc_mul_corr #(.N(6), .K(2)) dut_wide (
    .clk(clk), .rst(rst), .mode_i(mode), .a_i(a6), .b_i(b6), .prod_o(p6)
  );

  function automatic int ref_prod(int n, int k, int x, int y, int m);
    int base, sres, sgrd, top, e4, et, cc, vc, t;
    base = n - k;
    sres = 0; sgrd = 0; top = 0;
    for (int i = 0; i < n; i++) begin
      for (int j = 0; j < n; j++) begin
        int bit_v;
        bit_v = ((x >> i) & 1) & ((y >> j) & 1);
        if (i + j >= n)            sres += bit_v << (i + j - base);
        else if (i + j >= base)    sgrd += bit_v << (i + j - base);
        else if (i + j == base - 1) top += bit_v;
      end
    end
    e4 = 0;
    for (int c = 0; c < base; c++) e4 += (c + 1) << c;
    et = (1 << (n - 1)) - (1 << (base - 1));
    cc = (e4 + 4 * et + (2 << base)) / (4 << base);
    vc = (2 * et + (1 << base)) / (2 << base);
    case (m)
      1:       t = sres + sgrd + cc;
      2:       t = sres + sgrd + 2 * top + vc;
      default: t = sres;
    endcase
    return (t >> k) & ((1 << n) - 1);
  endfunction

  task automatic check(int got, int exp, string req, string what);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic report();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  function automatic string mode_tag(int m);
    case (m)
      0:       return "R3";
      1:       return "R4 R5";
      2:       return "R6";
      default: return "R7";
    endcase
  endfunction

  initial begin
    rst = 1'b1; mode = 2'b01;
    a4 = 4'd9; b4 = 4'd13; a6 = 6'd41; b6 = 6'd58;
    repeat (2) @(posedge clk);
    #1;
    check(p4, 0, "R1", "reset narrow");
    check(p6, 0, "R1", "reset wide");

    @(negedge clk); rst = 1'b0;

    for (int m = 0; m < 4; m++) begin
      for (int x = 0; x < 64; x++) begin
        for (int y = 0; y < 64; y++) begin
          @(negedge clk);
          mode = 2'(m);
          a4 = 4'(x); b4 = 4'(y); a6 = 6'(x); b6 = 6'(y);
          @(posedge clk); #1;
          check(p6, ref_prod(6, 2, x, y, m), mode_tag(m), "wide sweep");
          if (x < 16 && y < 16) begin
            check(p4, ref_prod(4, 1, x, y, m), mode_tag(m), "narrow sweep");
            if (m == 0)
              check(int'(p4 <= 4'((x * y) >> 4)), 1, "R9", "truncation bound");
            if (m == 3)
              check(p4, ref_prod(4, 1, x, y, 0), "R7", "reserved equals truncate");
          end
        end
      end
    end

    // R8: corrected sum wraps past 2^N
    @(negedge clk); mode = 2'b10; a4 = 4'd15; b4 = 4'd15;
    @(posedge clk); #1;
    check(p4, 0, "R8", "variable wrap");

    // R2: output holds between edges while inputs change
    @(negedge clk); mode = 2'b00; a4 = 4'd15; b4 = 4'd15;
    @(posedge clk); #1;
    check(p4, ref_prod(4, 1, 15, 15, 0), "R2", "captured");
    @(negedge clk); a4 = 4'd3; b4 = 4'd2; #1;
    check(p4, ref_prod(4, 1, 15, 15, 0), "R2", "held before edge");
    @(posedge clk); #1;
    check(p4, ref_prod(4, 1, 3, 2, 0), "R2", "updated after edge");

    // R1: reset in mid-run clears a nonzero product
    @(negedge clk); mode = 2'b01; a4 = 4'd15; b4 = 4'd14; a6 = 6'd63; b6 = 6'd60;
    @(posedge clk); #1;
    check(p4, ref_prod(4, 1, 15, 14, 1), "R4", "before reset");
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    check(p4, 0, "R1", "mid-run reset narrow");
    check(p6, 0, "R1", "mid-run reset wide");

    done = 1'b1;
    report();
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
      $finish;
    end
  end
endmodule